// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM of 16-bit words with a separate active-low select pin per byte lane. The host presents one word request at a time over a valid/ready handshake, giving a read/write flag, an 18-bit word address, write data and a two-bit byte-enable mask. The controller turns each request into the memory's chip-enable, write-strobe, output-enable and byte-lane sequence. It drives the write data through a pad-style output enable and samples the word that comes back on a read.

Every phase is sized in whole clock cycles at elaboration. The sizes come from nanosecond timing parameters and the clock period, so one netlist suits any clock rate. Writes are strobe-controlled with the output enable held inactive, which allows the shorter strobe width. A read always ends with a turnaround gap, so the host-side drivers never overlap the memory's output drivers while those are switching off. The address register is loaded only while the controller is idle, so the address never moves while the write strobe is low.

Top module: `sramc_ctrl`

## Requirements
- R1: While idle (including straight after reset) req_ready is 1, mem_ce_n, mem_we_n and mem_oe_n are 1, both mem_lane_n bits are 1 and mem_dq_oe is 0.
- R2: A read holds mem_ce_n and mem_oe_n low, with mem_we_n high, for exactly N_ACC cycles, where N_ACC is the largest of the clock counts of address access time, output-enable access time and read cycle time. The bus is sampled at the clock edge that ends that window. rd_valid is 1 for exactly one cycle, the (N_ACC+1)-th cycle after acceptance, and rd_data carries the sampled word.
- R3: req_be bit 0 enables data bits 7:0 (pin mem_lane_n[0]) and bit 1 enables bits 15:8 (mem_lane_n[1]). Only enabled lanes are pulled low during an access. A disabled lane is never written and returns zero on a read.
- R4: A write takes one setup cycle (CE low, data driven, WE high), then N_WP cycles with mem_we_n low, then one hold cycle with WE high and data still driven. mem_oe_n stays high throughout. N_WP is the largest of the strobe-width count, the data-setup count and the write-cycle count minus 2 (at least 1). Data is driven for N_WP+2 cycles.
- R5: mem_addr changes only while the controller is idle, never while mem_we_n is low or in the cycle it rises, and equals the request address for the whole access.
- R6: After a read, mem_oe_n is high and the bus undriven for at least N_TA cycles (the clock count of the output turn-off time) before the controller drives data. mem_dq_oe is never 1 while mem_oe_n is 0.
- R7: req_ready falls at acceptance and stays low for N_ACC+1+N_TA cycles on a read and N_WP+2 cycles on a write.
- R8: Each phase count is the phase's nanosecond value divided by the clock period, rounded up, with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte-lane enables, bit 0 = low byte |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | DATA_W | Read word, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | DATA_W/8 | Byte-lane selects, active low, bit 0 = low byte |
| mem_dq_out | output | DATA_W | Data driven to the memory |
| mem_dq_oe | output | 1 | Pad driver enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The hardest case to reach from the ports is a read that samples the bus too early, or a write that drives the bus before the memory has let go of it. Neither shows up at the host interface unless the memory model reacts to real elapsed time. The bench's model therefore returns bit-inverted data until both access times have passed since the address change and the output-enable fall. It counts a clash whenever the controller drives within the turn-off time after output enable rises. A read issued back to back with a write, under timing parameters chosen so that every phase spans several clocks, puts these windows exactly on the clock edges the controller picks.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_DONE,
    ST_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } sramc_state_t;

  // Whole clocks needed to cover a delay in ns, never less than one.
  function automatic int unsigned phase_clocks(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
module sramc_phase_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          done
);
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (load)             count <= len - CW'(1);
    else if (count != '0)      count <= count - CW'(1);
  end

  assign done = (count == '0);

  // A new phase is only started once the previous one has run out.
  assert_no_reload_R8: assert property (@(posedge clk) disable iff (!rst_n) load |-> done)
    else $error("timer reloaded mid-phase");

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int unsigned N_ACC = 1,
  parameter int unsigned N_WP  = 1,
  parameter int unsigned N_TA  = 1,
  parameter int unsigned CW    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          timer_done,
  output logic          req_ready,
  output logic          accept,
  output logic          timer_load,
  output logic [CW-1:0] timer_len,
  output logic          capture,
  output logic          rd_valid,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          lanes_on,
  output logic          drive
);
  sramc_state_t st, nx;

  always_comb begin
    nx         = st;
    timer_load = 1'b0;
    timer_len  = '0;
    unique case (st)
      ST_IDLE: if (req_valid) begin
        if (req_write) nx = ST_WR_SETUP;
        else begin
          nx = ST_RD_WAIT;
          timer_load = 1'b1;
          timer_len  = CW'(N_ACC);
        end
      end
      ST_RD_WAIT: if (timer_done) nx = ST_RD_DONE;
      ST_RD_DONE: begin
        nx = ST_TURN;
        timer_load = 1'b1;
        timer_len  = CW'(N_TA);
      end
      ST_TURN: if (timer_done) nx = ST_IDLE;
      ST_WR_SETUP: begin
        nx = ST_WR_PULSE;
        timer_load = 1'b1;
        timer_len  = CW'(N_WP);
      end
      ST_WR_PULSE: if (timer_done) nx = ST_WR_HOLD;
      ST_WR_HOLD: nx = ST_IDLE;
      default: nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nx;
  end

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign capture   = (st == ST_RD_WAIT) && timer_done;
  assign rd_valid  = (st == ST_RD_DONE);
  assign oe_n      = (st != ST_RD_WAIT);
  assign we_n      = (st != ST_WR_PULSE);
  assign drive     = (st == ST_WR_SETUP) || (st == ST_WR_PULSE) || (st == ST_WR_HOLD);
  assign lanes_on  = drive || (st == ST_RD_WAIT);
  assign ce_n      = !lanes_on;

  // Dwell counter kept apart from the phase timer, for the checks below.
  logic [CW-1:0] dwell;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dwell <= '0;
    else if (nx != st) dwell <= '0;
    else               dwell <= dwell + CW'(1);
  end

  assert_read_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD_WAIT && nx != ST_RD_WAIT) |-> dwell == CW'(N_ACC - 1))
    else $error("read window length wrong");

  assert_pulse_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR_PULSE && nx != ST_WR_PULSE) |-> dwell == CW'(N_WP - 1))
    else $error("write strobe length wrong");

  assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid)
    else $error("rd_valid longer than one cycle");

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n) accept |=> !req_ready)
    else $error("ready high right after acceptance");

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              lanes_on,
  input  logic              drive,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_lane_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] lane_masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_masked[g*8 +: 8] = be_q[g] ? mem_dq_in[g*8 +: 8] : 8'h00;
    assign mem_lane_n[g]         = !(lanes_on && be_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (capture) rd_q <= lane_masked;
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = drive;
  assign rd_data    = rd_q;

endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_AA_NS       = 10,
  parameter int unsigned T_OE_NS       = 5,
  parameter int unsigned T_RC_NS       = 10,
  parameter int unsigned T_WP_NS       = 7,
  parameter int unsigned T_DW_NS       = 5,
  parameter int unsigned T_WC_NS       = 10,
  parameter int unsigned T_OHZ_NS      = 5,
  localparam int unsigned LANES        = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_lane_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned C_AA    = phase_clocks(T_AA_NS,  CLK_PERIOD_NS);
  localparam int unsigned C_OE    = phase_clocks(T_OE_NS,  CLK_PERIOD_NS);
  localparam int unsigned C_RC    = phase_clocks(T_RC_NS,  CLK_PERIOD_NS);
  localparam int unsigned C_WP    = phase_clocks(T_WP_NS,  CLK_PERIOD_NS);
  localparam int unsigned C_DW    = phase_clocks(T_DW_NS,  CLK_PERIOD_NS);
  localparam int unsigned C_WC    = phase_clocks(T_WC_NS,  CLK_PERIOD_NS);
  localparam int unsigned WC_REST = (C_WC > 2) ? C_WC - 2 : 1;
  localparam int unsigned N_ACC   = umax(umax(C_AA, C_OE), C_RC);
  localparam int unsigned N_WP    = umax(umax(C_WP, C_DW), WC_REST);
  localparam int unsigned N_TA    = phase_clocks(T_OHZ_NS, CLK_PERIOD_NS);
  localparam int unsigned MAXN    = umax(umax(N_ACC, N_WP), N_TA);
  localparam int unsigned CW      = $clog2(MAXN + 1);

  logic          accept, capture, lanes_on, drive;
  logic          timer_load, timer_done;
  logic [CW-1:0] timer_len;

  sramc_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .len(timer_len), .done(timer_done)
  );

  sramc_seq #(.N_ACC(N_ACC), .N_WP(N_WP), .N_TA(N_TA), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .timer_done(timer_done), .req_ready(req_ready), .accept(accept),
    .timer_load(timer_load), .timer_len(timer_len), .capture(capture),
    .rd_valid(rd_valid), .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n),
    .lanes_on(lanes_on), .drive(drive)
  );

  sramc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .lanes_on(lanes_on), .drive(drive), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .rd_data(rd_data)
  );

  // Clocks since output enable last went inactive, saturating at N_TA.
  logic [CW-1:0] oe_idle_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         oe_idle_cnt <= CW'(N_TA);
    else if (!mem_oe_n)                 oe_idle_cnt <= '0;
    else if (oe_idle_cnt < CW'(N_TA))   oe_idle_cnt <= oe_idle_cnt + CW'(1);
  end

  assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_lane_n)))
    else $error("not in standby while idle");

  assert_write_oe_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dq_oe))
    else $error("write strobe without CE, data or with OE low");

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe)
    else $error("data released as strobe rose");

  assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || $past(!mem_we_n)) |-> $stable(mem_addr))
    else $error("address moved around the write strobe");

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n)
    else $error("driving while memory outputs enabled");

  assert_turnaround_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_idle_cnt >= CW'(N_TA)))
    else $error("turnaround gap too short");

endmodule

// File: tb/sramc_ctrl_test.sv
module sramc_ctrl_test;
  localparam int P    = 20;
  localparam int TAA  = 55;
  localparam int TOE  = 25;
  localparam int TRC  = 55;
  localparam int TWP  = 30;
  localparam int TDW  = 15;
  localparam int TWC  = 55;
  localparam int TOHZ = 35;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rd_valid;
  logic [15:0] rd_data;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dq_out;
  logic [15:0] model_dq = '0;

  always #10 clk = ~clk;

  sramc_ctrl #(
    .ADDR_W(18), .DATA_W(16), .CLK_PERIOD_NS(P), .T_AA_NS(TAA), .T_OE_NS(TOE),
    .T_RC_NS(TRC), .T_WP_NS(TWP), .T_DW_NS(TDW), .T_WC_NS(TWC), .T_OHZ_NS(TOHZ)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(model_dq)
  );

  // ---------------- timed memory model ----------------
  logic [15:0] store  [int];
  logic [15:0] shadow [int];
  time  t_addr = 0, t_oe_fall = 0, t_oe_rise = 0, t_we_fall = 0, t_dq = 0;
  logic [17:0] addr_at_fall = '0;
  logic oe_low_in_pulse = 1'b0;
  int viol = 0, clash = 0;

  always @(mem_addr) t_addr = $time;
  always @(posedge mem_oe_n) t_oe_rise = $time;
  always @(negedge mem_oe_n) begin
    t_oe_fall = $time;
    if (!mem_we_n) oe_low_in_pulse = 1'b1;
  end
  always @(mem_dq_out or mem_dq_oe) t_dq = $time;
  always @(negedge mem_we_n) begin
    t_we_fall = $time;
    addr_at_fall = mem_addr;
    oe_low_in_pulse = !mem_oe_n;
  end
  always @(posedge mem_we_n) begin
    int k;
    logic [15:0] w;
    if (!mem_ce_n) begin
      if ($time - t_we_fall < TWP) viol++;
      if ($time - t_dq < TDW) viol++;
      if (mem_addr !== addr_at_fall) viol++;
      if (oe_low_in_pulse || !mem_oe_n) viol++;
      if (!mem_dq_oe) viol++;
      k = int'(mem_addr);
      w = store.exists(k) ? store[k] : 16'h0000;
      for (int l = 0; l < 2; l++)
        if (!mem_lane_n[l]) w[l*8 +: 8] = mem_dq_out[l*8 +: 8];
      store[k] = w;
    end
  end
  always begin
    int k;
    logic [15:0] w;
    bit ok;
    #1;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      k = int'(mem_addr);
      w = store.exists(k) ? store[k] : 16'h0000;
      ok = ($time - t_addr >= TAA) && ($time - t_oe_fall >= TOE);
      for (int l = 0; l < 2; l++)
        model_dq[l*8 +: 8] = mem_lane_n[l] ? 8'hFF : (ok ? w[l*8 +: 8] : ~w[l*8 +: 8]);
    end else begin
      model_dq = 16'h0000;
    end
    if (mem_dq_oe && ((!mem_oe_n && !mem_ce_n) || ($time - t_oe_rise < TOHZ))) clash++;
  end

  // ---------------- bench bookkeeping ----------------
  int checks = 0, failures = 0;
  bit finished = 1'b0;
  int e_acc, e_wp, e_ta;

  function automatic int clk_count(int ns);
    int c;
    c = ns / P;
    if (c * P < ns) c++;
    if (c < 1) c = 1;
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int busy, we_low, oe_low, drv_cyc, addr_bad, rv_count, rv_at;
  logic [1:0]  lanes_seen;
  logic [15:0] rdat;

  // Issues one request; called and returning at a falling clock edge with ready high.
  task automatic go(input logic wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    int n;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0; we_low = 0; oe_low = 0; drv_cyc = 0; addr_bad = 0;
    rv_count = 0; rv_at = 0; lanes_seen = 2'b00; rdat = 16'h0;
    n = 1;
    while (!req_ready) begin
      busy++;
      if (!mem_we_n) we_low++;
      if (!mem_oe_n) oe_low++;
      if (mem_dq_oe) drv_cyc++;
      lanes_seen = lanes_seen | ~mem_lane_n;
      if (mem_addr !== a) addr_bad++;
      if (rd_valid) begin rv_count++; rv_at = n; rdat = rd_data; end
      n++;
      @(negedge clk);
    end
    if (wr) begin
      logic [15:0] w;
      w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      shadow[int'(a)] = w;
    end
  endtask

  function automatic logic [15:0] expect_rd(input logic [17:0] a, input logic [1:0] be);
    logic [15:0] w;
    w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    if (!be[0]) w[7:0]  = 8'h00;
    if (!be[1]) w[15:8] = 8'h00;
    return w;
  endfunction

  task automatic check_standby(input string tag);
    chk({tag, " R1 ready"}, req_ready, 1);
    chk({tag, " R1 strobes"}, {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk({tag, " R1 lanes"}, mem_lane_n, 2'b11);
    chk({tag, " R1 drive"}, mem_dq_oe, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic test_reset();
    check_standby("reset");
    chk("reset R2 rd_valid", rd_valid, 0);
  endtask

  task automatic test_full_write();
    go(1'b1, 18'h12345, 16'hA55A, 2'b11);
    chk("write R7 busy", busy, e_wp + 2);
    chk("write R4 strobe cycles", we_low, e_wp);
    chk("write R4 oe stays high", oe_low, 0);
    chk("write R4 drive cycles", drv_cyc, e_wp + 2);
    chk("write R3 lanes", lanes_seen, 2'b11);
    chk("write R5 address", addr_bad, 0);
    chk("write R4 R8 memory timing", viol, 0);
    check_standby("after write");
  endtask

  task automatic test_full_read();
    go(1'b0, 18'h12345, 16'h0, 2'b11);
    chk("read R2 data", rdat, expect_rd(18'h12345, 2'b11));
    chk("read R2 one pulse", rv_count, 1);
    chk("read R2 pulse cycle", rv_at, e_acc + 1);
    chk("read R8 oe window", oe_low, e_acc);
    chk("read R2 we high", we_low, 0);
    chk("read R7 busy", busy, e_acc + 1 + e_ta);
    chk("read R5 address", addr_bad, 0);
  endtask

  task automatic test_byte_writes();
    go(1'b1, 18'h12345, 16'h1234, 2'b01);
    chk("byte0 write R3 lanes", lanes_seen, 2'b01);
    go(1'b0, 18'h12345, 16'h0, 2'b11);
    chk("byte0 write R3 data", rdat, 16'hA534);
    go(1'b1, 18'h12345, 16'h7788, 2'b10);
    chk("byte1 write R3 lanes", lanes_seen, 2'b10);
    go(1'b0, 18'h12345, 16'h0, 2'b11);
    chk("byte1 write R3 data", rdat, 16'h7734);
    chk("byte writes R4 memory timing", viol, 0);
  endtask

  task automatic test_masked_reads();
    go(1'b0, 18'h12345, 16'h0, 2'b10);
    chk("upper read R3 data", rdat, 16'h7700);
    chk("upper read R3 lanes", lanes_seen, 2'b10);
    go(1'b0, 18'h12345, 16'h0, 2'b01);
    chk("lower read R3 data", rdat, 16'h0034);
    go(1'b0, 18'h12345, 16'h0, 2'b00);
    chk("no-lane read R3 data", rdat, 16'h0000);
    chk("no-lane read R3 lanes", lanes_seen, 2'b00);
    chk("no-lane read R2 pulse", rv_count, 1);
  endtask

  task automatic test_turnaround();
    go(1'b1, 18'h00100, 16'h0F0F, 2'b11);
    go(1'b0, 18'h00100, 16'h0, 2'b11);
    chk("rw pair R2 data", rdat, 16'h0F0F);
    go(1'b1, 18'h00101, 16'hBEEF, 2'b11);
    go(1'b0, 18'h00101, 16'h0, 2'b11);
    go(1'b1, 18'h00100, 16'hC3C3, 2'b11);
    go(1'b0, 18'h00100, 16'h0, 2'b11);
    chk("read-write R6 data", rdat, 16'hC3C3);
    go(1'b0, 18'h00101, 16'h0, 2'b11);
    chk("back-to-back R6 data", rdat, 16'hBEEF);
    chk("turnaround R6 no clash", clash, 0);
  endtask

  task automatic test_addr_edges();
    go(1'b1, 18'h00000, 16'h1111, 2'b11);
    go(1'b1, 18'h3FFFF, 16'hEEEE, 2'b11);
    chk("top address R5 hold", addr_bad, 0);
    go(1'b0, 18'h00000, 16'h0, 2'b11);
    chk("bottom address R5 data", rdat, 16'h1111);
    go(1'b0, 18'h3FFFF, 16'h0, 2'b11);
    chk("top address R5 data", rdat, 16'hEEEE);
    chk("edges R4 memory timing", viol, 0);
    chk("edges R6 no clash", clash, 0);
  endtask

  initial begin
    e_acc = clk_count(TAA);
    if (clk_count(TOE) > e_acc) e_acc = clk_count(TOE);
    if (clk_count(TRC) > e_acc) e_acc = clk_count(TRC);
    e_wp = clk_count(TWP);
    if (clk_count(TDW) > e_wp) e_wp = clk_count(TDW);
    if (clk_count(TWC) - 2 > e_wp) e_wp = clk_count(TWC) - 2;
    e_ta = clk_count(TOHZ);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_full_write();
    test_full_read();
    test_byte_writes();
    test_masked_reads();
    test_turnaround();
    test_addr_edges();
    check_standby("end");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R7 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule